// File: doc/BRIEF.md
# Device Configuration Sequencer

This block steps a programmable device from power-on, or from a reconfiguration request made by the user, through to normal operation. It first waits until the I/O and core supplies both report good. It then clears the configuration memory and waits for that to finish. An outside agent can prolong the clearing phase by keeping either the active-low program request low or the shared INIT line low. When the clearing phase ends, the block samples the mode pins. It then accepts a fixed number of configuration frames and checks the last frame against a CRC computed outside the block. If the check fails, the block stops with INIT pulled low. If it passes, the start-up steps run one after another.

INIT is an open-drain line that several parties share. The block only ever pulls it low or lets it go, and it reads the line back through a synchroniser. The program request is synchronised in the same way. The memory array and the CRC polynomial core are outside this block. Clearing is modelled by an internal timer that takes a start pulse and returns a done pulse after `CLEAR_CYCLES` cycles. The CRC core is represented by its result, supplied on `crc_calc_i`.

Frames arrive on a valid/ready port. A frame is taken on a rising clock edge only when `frm_valid_i` and `frm_ready_o` are both high. `frm_ready_o` is high only during the load phase. While `frm_valid_i` is high and `frm_ready_o` is low, the source must hold `frm_data_i` steady.

Top module: `cfg_sequencer`

## Requirements
- R1: While `vcco_good_i` or `vccint_good_i` is low, the block returns to (or stays in) the supply wait: `init_pull_low_o`=1, `done_o`=0, `io_enable_o`=0, `gsr_release_o`=0, `frm_ready_o`=0. Clearing starts on the first edge at which both supplies are high.
- R2: If the synchronised program request is low in the load phase, in a start-up step, in user operation or in the error state, the block re-enters clearing on the next edge. `init_pull_low_o` becomes 1 and `done_o`, `io_enable_o` and `gsr_release_o` become 0.
- R3: Clearing keeps `init_pull_low_o`=1 for exactly `CLEAR_CYCLES` clock cycles. After that, INIT is released (`init_pull_low_o`=0), unless the program request is still low.
- R4: After the clear timer finishes, the block stays in the clearing phase for as long as the synchronised program request is low or the synchronised `init_in_i` is low. While the program request is low, the block keeps pulling INIT low.
- R5: On the edge where the synchronised INIT readback is first seen high (with the program request high), `mode_i` is captured into `mode_o` and the load phase begins.
- R6: `frm_ready_o` is 1 only in the load phase. A frame is counted only on an edge with `frm_valid_i`=1 and `frm_ready_o`=1.
- R7: The `NUM_FRAMES`-th accepted frame carries the embedded CRC. If it is not equal to `crc_calc_i`, the block enters the error state: `init_pull_low_o`=1, `frm_ready_o`=0, `done_o`=0.
- R8: The error state is left only when the program request goes low or a supply drops. Any other input leaves it unchanged.
- R9: If the CRC matches, the outputs turn on over consecutive cycles. First `done_o`=1. On the next cycle `io_enable_o`=1 is added. On the cycle after that `gsr_release_o`=1 is added, and the block is then in user operation.
- R10: `prog_n_i` and `init_in_i` each pass through two flops. A low program request applied before edge k takes effect on the outputs after edge k+2.
- R11: Outside the capture edge, `mode_o` does not follow `mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vcco_good_i | input | 1 | I/O supply good |
| vccint_good_i | input | 1 | Core supply good |
| prog_n_i | input | 1 | Active-low reconfiguration request (asynchronous) |
| init_in_i | input | 1 | Readback of the shared INIT line (asynchronous) |
| init_pull_low_o | output | 1 | 1 pulls INIT low, 0 releases it (open-drain enable) |
| mode_i | input | MODE_W | Mode pins |
| mode_o | output | MODE_W | Mode value captured when INIT rises |
| frm_valid_i | input | 1 | Frame valid |
| frm_ready_o | output | 1 | Frame ready (load phase only) |
| frm_data_i | input | FRAME_W | Frame data; the last frame carries the embedded CRC |
| crc_calc_i | input | FRAME_W | CRC computed by the external core |
| done_o | output | 1 | DONE indication |
| io_enable_o | output | 1 | User I/O enable |
| gsr_release_o | output | 1 | Global set/reset release |

## Verification
The assertions check these properties on every cycle:
- a supply drop forces the wait state;
- a program request during loading, start-up, user operation or error forces a return to clearing;
- the clearing phase is held while the program request or the INIT readback is low;
- the mode value is captured as the block enters loading;
- the error state is sticky;
- I/O enable only rises after DONE, and set/reset release only rises after I/O enable.

Other behaviour can only be shown by the bench's scenarios. These include:
- the exact clearing length;
- the three-edge reaction to the program request;
- frames offered during back-pressure being ignored;
- a bad CRC after gapped frames;
- a supply drop in the middle of loading.

The bench also compares every output against its cycle model on every clock.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [3:0] {
    ST_WAIT_PWR,
    ST_CLEAR,
    ST_RELEASE,
    ST_LOAD,
    ST_SU_DONE,
    ST_SU_IO,
    ST_SU_GSR,
    ST_USER,
    ST_ERROR
  } cfg_state_e;
endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter int   WIDTH   = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= {WIDTH{RST_VAL}};
      stable_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q   <= d_i;
      stable_q <= meta_q;
    end
  end

  assign q_o = stable_q;
endmodule

// File: rtl/cfg_clear_timer.sv
module cfg_clear_timer #(
  parameter int CLEAR_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CLEAR_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = busy_q && (cnt_q == LAST) && !start_i;

  AST_CLEAR_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o) else $error("clear done right after start"); // R3
endmodule

// File: rtl/cfg_frame_loader.sv
module cfg_frame_loader #(
  parameter int NUM_FRAMES = 4,
  parameter int FRAME_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               accept_i,
  input  logic [FRAME_W-1:0] data_i,
  input  logic [FRAME_W-1:0] crc_calc_i,
  output logic               last_o,
  output logic               crc_ok_o
);
  localparam int CW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam logic [CW-1:0] LAST = CW'(NUM_FRAMES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) cnt_q <= '0;
    else if (accept_i)     cnt_q <= cnt_q + 1'b1;
  end

  assign last_o   = accept_i && (cnt_q == LAST);
  assign crc_ok_o = (data_i == crc_calc_i);
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
  import cfg_seq_pkg::*;
#(
  parameter int MODE_W       = 3,
  parameter int FRAME_W      = 16,
  parameter int NUM_FRAMES   = 4,
  parameter int CLEAR_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vcco_good_i,
  input  logic               vccint_good_i,
  input  logic               prog_n_i,
  input  logic               init_in_i,
  output logic               init_pull_low_o,
  input  logic [MODE_W-1:0]  mode_i,
  output logic [MODE_W-1:0]  mode_o,
  input  logic               frm_valid_i,
  output logic               frm_ready_o,
  input  logic [FRAME_W-1:0] frm_data_i,
  input  logic [FRAME_W-1:0] crc_calc_i,
  output logic               done_o,
  output logic               io_enable_o,
  output logic               gsr_release_o
);
  cfg_state_e        state_q, state_d;
  logic              prog_s, init_s, supply_ok;
  logic              clr_start, clr_done;
  logic              frm_last, frm_crc_ok;
  logic [MODE_W-1:0] mode_q;

  cfg_sync2 #(.WIDTH(1), .RST_VAL(1'b1)) u_prog_sync (
    .clk(clk), .rst_n(rst_n), .d_i(prog_n_i), .q_o(prog_s));

  cfg_sync2 #(.WIDTH(1), .RST_VAL(1'b0)) u_init_sync (
    .clk(clk), .rst_n(rst_n), .d_i(init_in_i), .q_o(init_s));

  cfg_clear_timer #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_clear (
    .clk(clk), .rst_n(rst_n), .start_i(clr_start), .done_o(clr_done));

  cfg_frame_loader #(.NUM_FRAMES(NUM_FRAMES), .FRAME_W(FRAME_W)) u_frames (
    .clk(clk), .rst_n(rst_n), .clear_i(state_q != ST_LOAD),
    .accept_i(frm_valid_i && frm_ready_o), .data_i(frm_data_i),
    .crc_calc_i(crc_calc_i), .last_o(frm_last), .crc_ok_o(frm_crc_ok));

  assign supply_ok = vcco_good_i && vccint_good_i;

  always_comb begin
    state_d = state_q;
    if (!supply_ok) begin
      state_d = ST_WAIT_PWR;
    end else begin
      case (state_q)
        ST_WAIT_PWR: state_d = ST_CLEAR;
        ST_CLEAR:    if (clr_done) state_d = ST_RELEASE;
        ST_RELEASE:  if (prog_s && init_s) state_d = ST_LOAD;
        ST_LOAD: begin
          if (!prog_s)       state_d = ST_CLEAR;
          else if (frm_last) state_d = frm_crc_ok ? ST_SU_DONE : ST_ERROR;
        end
        ST_SU_DONE:  state_d = prog_s ? ST_SU_IO  : ST_CLEAR;
        ST_SU_IO:    state_d = prog_s ? ST_SU_GSR : ST_CLEAR;
        ST_SU_GSR:   state_d = prog_s ? ST_USER   : ST_CLEAR;
        ST_USER:     if (!prog_s) state_d = ST_CLEAR;
        ST_ERROR:    if (!prog_s) state_d = ST_CLEAR;
        default:     state_d = ST_WAIT_PWR;
      endcase
    end
  end

  assign clr_start = (state_q != ST_CLEAR) && (state_d == ST_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_PWR;
      mode_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RELEASE && state_d == ST_LOAD) mode_q <= mode_i;
    end
  end

  assign mode_o          = mode_q;
  assign init_pull_low_o = (state_q == ST_WAIT_PWR) || (state_q == ST_CLEAR) ||
                           (state_q == ST_ERROR) || (state_q == ST_RELEASE && !prog_s);
  assign frm_ready_o     = (state_q == ST_LOAD);
  assign done_o          = (state_q == ST_SU_DONE) || (state_q == ST_SU_IO) ||
                           (state_q == ST_SU_GSR)  || (state_q == ST_USER);
  assign io_enable_o     = (state_q == ST_SU_IO) || (state_q == ST_SU_GSR) ||
                           (state_q == ST_USER);
  assign gsr_release_o   = (state_q == ST_SU_GSR) || (state_q == ST_USER);

  AST_SUPPLY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (init_pull_low_o && !done_o && !frm_ready_o)) else $error("supply wait"); // R1
  AST_PROG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !prog_s && (frm_ready_o || done_o || state_q == ST_ERROR))
    |=> (state_q == ST_CLEAR && init_pull_low_o && !done_o)) else $error("prog restart"); // R2
  AST_CLEAR_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && state_q == ST_RELEASE && !(prog_s && init_s))
    |=> (state_q == ST_RELEASE && !frm_ready_o)) else $error("stretch"); // R4
  AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && state_q == ST_RELEASE && prog_s && init_s)
    |=> (frm_ready_o && mode_o == $past(mode_i))) else $error("mode capture"); // R5
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && prog_s && state_q == ST_ERROR)
    |=> (state_q == ST_ERROR && init_pull_low_o)) else $error("error sticky"); // R8
  AST_IO_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_enable_o) |-> (done_o && $past(done_o))) else $error("io order"); // R9
  AST_GSR_AFTER_IO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gsr_release_o) |-> $past(io_enable_o)) else $error("gsr order"); // R9
endmodule

// File: tb/cfg_sequencer_bench.sv
module cfg_sequencer_bench;
  localparam int MODE_W = 3, FRAME_W = 16, NUM_FRAMES = 4, CLEAR_CYCLES = 8;
  localparam logic [FRAME_W-1:0] CRC = 16'hBEEF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vcco = 1'b0, vccint = 1'b0, prog_n = 1'b1, ext_hold = 1'b0;
  logic init_in, init_pull_low, frm_valid = 1'b0, frm_ready;
  logic done, io_en, gsr_rel;
  logic [MODE_W-1:0]  mode_in = '0, mode_out;
  logic [FRAME_W-1:0] frm_data = '0;

  int ntests = 0, nfail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  assign init_in = ~(init_pull_low | ext_hold);

  cfg_sequencer #(.MODE_W(MODE_W), .FRAME_W(FRAME_W), .NUM_FRAMES(NUM_FRAMES),
                  .CLEAR_CYCLES(CLEAR_CYCLES)) u_cfg_sequencer (
    .clk(clk), .rst_n(rst_n), .vcco_good_i(vcco), .vccint_good_i(vccint),
    .prog_n_i(prog_n), .init_in_i(init_in), .init_pull_low_o(init_pull_low),
    .mode_i(mode_in), .mode_o(mode_out), .frm_valid_i(frm_valid),
    .frm_ready_o(frm_ready), .frm_data_i(frm_data), .crc_calc_i(CRC),
    .done_o(done), .io_enable_o(io_en), .gsr_release_o(gsr_rel));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model. Phases: 0 wait, 1 clear, 2 release, 3 load, 4..6 start-up, 7 user, 8 error
  int m_ph = 0, m_clr = 0, m_cnt = 0;
  bit m_p1 = 1, m_p2 = 1, m_i1 = 0, m_i2 = 0;
  logic [MODE_W-1:0] m_mode = '0;

  function automatic bit m_pull(); return (m_ph == 0 || m_ph == 1 || m_ph == 8 || (m_ph == 2 && !m_p2)); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_clr = 0; m_cnt = 0; m_p1 = 1; m_p2 = 1; m_i1 = 0; m_i2 = 0; m_mode = '0;
    end else begin
      bit line;
      bit take;
      int nx;
      line = !(m_pull() || ext_hold);
      take = frm_valid && (m_ph == 3);
      nx = m_ph;
      if (!(vcco && vccint)) nx = 0;
      else if (m_ph == 0) nx = 1;
      else if (m_ph == 1) begin if (m_clr == CLEAR_CYCLES - 1) nx = 2; else m_clr++; end
      else if (m_ph == 2) begin if (m_p2 && m_i2) begin nx = 3; m_mode = mode_in; m_cnt = 0; end end
      else if (!m_p2) nx = 1;
      else if (m_ph == 3) begin
        if (take) begin
          if (m_cnt == NUM_FRAMES - 1) nx = (frm_data == CRC) ? 4 : 8;
          else m_cnt++;
        end
      end
      else if (m_ph >= 4 && m_ph <= 6) nx = m_ph + 1;
      if (nx == 1 && m_ph != 1) m_clr = 0;
      m_ph = nx;
      m_p2 = m_p1; m_p1 = prog_n;
      m_i2 = m_i1; m_i1 = line;
    end
  end

  function automatic string ph_tag(int p);
    case (p)
      0: return "R1"; 1: return "R3"; 2: return "R4"; 3: return "R6"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [5+MODE_W-1:0] act, exp;
      act = {init_pull_low, done, io_en, gsr_rel, frm_ready, mode_out};
      exp = {m_pull(), m_ph >= 4 && m_ph <= 7, m_ph >= 5 && m_ph <= 7,
             m_ph >= 6 && m_ph <= 7, m_ph == 3, m_mode};
      chk(act == exp, {"model ", ph_tag(m_ph)}, int'(act), int'(exp));
    end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic wait_ready(); while (!frm_ready) @(negedge clk); endtask
  task automatic push(input logic [FRAME_W-1:0] d);
    frm_valid = 1'b1; frm_data = d;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nfail++; ntests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    int n;
    mode_in = 3'd5;
    cyc(3); rst_n = 1'b1; @(negedge clk);
    chk(init_pull_low && !done && !frm_ready, "R1 reset state", int'(init_pull_low), 1);
    vcco = 1'b1; cyc(5);
    chk(init_pull_low == 1'b1, "R1 one supply only", int'(init_pull_low), 1);
    vccint = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (init_pull_low && n < 100);
    chk(n == CLEAR_CYCLES + 1, "R3 clear length", n - 1, CLEAR_CYCLES);
    wait_ready();
    chk(mode_out == 3'd5, "R5 mode capture", int'(mode_out), 5);
    mode_in = 3'd2; cyc(3);
    chk(mode_out == 3'd5, "R11 mode ignored", int'(mode_out), 5);
    // gapped frames, bad CRC
    push(16'h0001); cyc(2);
    frm_valid = 1'b0; frm_data = 16'h1234; cyc(2);
    push(16'h0002); push(16'h0003); push(16'h0BAD);
    chk(init_pull_low && !done && !frm_ready, "R7 crc mismatch", int'(init_pull_low), 1);
    frm_valid = 1'b1; frm_data = CRC; cyc(10); frm_valid = 1'b0;
    chk(init_pull_low && !frm_ready && !done, "R8 error sticky", int'(frm_ready), 0);
    // reconfigure with external INIT stretch
    ext_hold = 1'b1; prog_n = 1'b0; cyc(4); prog_n = 1'b1;
    cyc(CLEAR_CYCLES + 20);
    chk(!init_pull_low && !frm_ready, "R4 external INIT stretch", int'(frm_ready), 0);
    ext_hold = 1'b0; mode_in = 3'd6;
    wait_ready();
    chk(frm_ready && mode_out == 3'd6, "R2 restart from error", int'(mode_out), 6);
    // good load and start-up order
    push(16'h00A0); push(16'h00A1); push(16'h00A2); push(CRC);
    chk(done && !io_en && !gsr_rel, "R9 step done", int'({done, io_en, gsr_rel}), 4);
    @(negedge clk);
    chk(done && io_en && !gsr_rel, "R9 step io", int'({done, io_en, gsr_rel}), 6);
    @(negedge clk);
    chk(done && io_en && gsr_rel && !frm_ready, "R9 step gsr", int'({done, io_en, gsr_rel}), 7);
    cyc(3);
    // program request from user operation, held to stretch clearing
    prog_n = 1'b0; cyc(2);
    chk(done == 1'b1, "R10 two-flop delay", int'(done), 1);
    @(negedge clk);
    chk(!done && !io_en && !gsr_rel && init_pull_low, "R2 restart from user", int'(done), 0);
    cyc(CLEAR_CYCLES + 15);
    chk(init_pull_low == 1'b1, "R4 program held low", int'(init_pull_low), 1);
    prog_n = 1'b1;
    wait_ready();
    // supply drop during load
    push(16'h0010); push(16'h0011);
    vccint = 1'b0; @(negedge clk);
    chk(init_pull_low && !frm_ready && !done, "R1 supply drop", int'(frm_ready), 0);
    cyc(4); vccint = 1'b1;
    wait_ready();
    push(16'h0020); push(16'h0021); push(16'h0022); push(CRC);
    cyc(3);
    chk(done && io_en && gsr_rel, "R9 user after power cycle", int'({done, io_en, gsr_rel}), 7);
    cyc(2);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule